// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block sits beside a memory port and judges each incoming transaction against a small table of protection rules. A transaction presents the megabyte it targets, the master ID of its issuer, the port it entered through and whether it is secure. One clock after the request is taken, the block returns a single verdict bit: accept or reject.

Software never touches the rule table directly. It fills three staging registers (window, ID range and attributes) and then writes a command word that names a rule and either commits the staged values into that rule or fetches that rule back into the staging registers. A separate per-port default mask supplies the verdict for a transaction that no valid rule covers. When more than one valid rule covers a transaction, the rule with the lowest number decides.

Requests and responses use valid/ready handshakes. The single response register holds one verdict. A new request is taken only when that register is empty or is being drained in the same cycle. A response held by a low `resp_ready` keeps its verdict unchanged until it is taken.

Top module: `mem_prot_checker`

## Requirements
- R1: The table holds 20 rules, numbered 0 to 19. The rule number is written in bits 4:0 of the command register (select 0), and reading select 0 returns the last number written there. A command that names a rule number of 20 or more changes neither the table nor the staging registers.
- R2: If a command word has bit 5 set, the staged window, ID and attribute values are copied into the named rule. If it has bit 6 set, the named rule is copied into those staging registers. If both bits are set, only the copy into the rule happens. Rule valid bits change only through a command with bit 5 set.
- R3: The window register (select 1) holds the low megabyte in bits 11:0 and the high megabyte in bits 23:12. A rule covers the request megabyte `req_page` when low <= page <= high, so both ends are included.
- R4: The ID register (select 2) holds the low master ID in bits 11:0 and the high master ID in bits 23:12. A rule covers `req_id` when low <= ID <= high, so both ends are included.
- R5: The attribute register (select 3) is laid out as follows. Bits 1:0 are the security field: bit 0 permits secure requests and bit 1 permits non-secure requests. Bit 2 is the valid bit. Bits 12:3 are the port mask, with bit 3+p for port p. Bit 13 is the result bit: 1 rejects and 0 accepts. A rule applies only when it is valid, its window and ID range contain the request, the request's port bit is set in the mask, and the security field permits the request.
- R6: The default register (select 4) holds 10 bits, one per port. When no rule applies, the verdict is the bit for the request's port. A port number of 10 or more is rejected when no rule applies.
- R7: When several rules apply, the lowest-numbered one gives the verdict.
- R8: After reset, every rule, every staging register, the command index and the default mask are zero, and no response is pending. Reads from selects 5 to 7 return zero.
- R9: A request is taken when `req_valid` and `req_ready` are both high, where `req_ready` = !`resp_valid` || `resp_ready`. The verdict appears on `resp_reject` with `resp_valid` on the next cycle. A pending response with `resp_ready` low keeps `resp_valid` and `resp_reject` unchanged.
- R10: A request taken in the same cycle as a configuration write is judged against the table as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 command, 1 window, 2 ID range, 3 attributes, 4 default mask |
| cfg_wdata | input | 24 | Configuration write data |
| cfg_rdata | output | 24 | Read data of the selected register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_page | input | 12 | Address bits 31:20 of the request (megabyte number) |
| req_id | input | 12 | Master ID of the request |
| req_port | input | 4 | Port number of the request |
| req_secure | input | 1 | 1 for a secure request |
| resp_valid | output | 1 | Verdict present |
| resp_ready | input | 1 | Verdict can be taken |
| resp_reject | output | 1 | 1 reject, 0 accept |

## Verification
The checks probe requests at each edge of a rule's window and ID range, one step inside and one step outside, to tell inclusive bounds from exclusive ones. Each security value and a lone port-mask bit are each tried with both request kinds, so a swapped security bit or a port decoded one place off shows up. Overlapping rules are given opposite results at both ends of the table, which separates lowest-number priority from highest-number priority and from a plain OR of the rules. Commands that name an out-of-range rule, commands with both bits set, a request that arrives together with a commit, and a verdict held under back-pressure each separate the intended ordering from its nearest wrong alternative.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int NUM_RULES = 20;
  localparam int NUM_PORTS = 10;
  localparam int PAGE_W    = 12;
  localparam int ID_W      = 12;
  localparam int CFG_W     = 24;

  localparam int IDX_W     = $clog2(NUM_RULES);
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int PORT_SPAN = 1 << PORT_W;

  // Command word layout
  localparam int CMD_IDX_W      = 5;
  localparam int CMD_COMMIT_BIT = 5;
  localparam int CMD_FETCH_BIT  = 6;

  // Staging register widths
  localparam int WIN_W  = 2 * PAGE_W;
  localparam int IDR_W  = 2 * ID_W;
  localparam int ATTR_W = NUM_PORTS + 4;
  localparam int RULE_W = WIN_W + IDR_W + ATTR_W;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_WIN  = 3'd1,
    SEL_IDR  = 3'd2,
    SEL_ATTR = 3'd3,
    SEL_DEF  = 3'd4
  } cfg_sel_e;

  // Field order mirrors {window, id range, attributes} so that a rule is the
  // concatenation of the three staging registers.
  typedef struct packed {
    logic [PAGE_W-1:0]    page_hi;
    logic [PAGE_W-1:0]    page_lo;
    logic [ID_W-1:0]      id_hi;
    logic [ID_W-1:0]      id_lo;
    logic                 reject;
    logic [NUM_PORTS-1:0] port_mask;
    logic                 valid;
    logic                 allow_ns;
    logic                 allow_s;
  } rule_t;
endpackage

// File: rtl/prc_rule_bank.sv
module prc_rule_bank
  import prc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  output rule_t                rules_o [NUM_RULES],
  output logic [NUM_PORTS-1:0] def_mask_o
);
  localparam logic [CMD_IDX_W-1:0] LAST_IDX = CMD_IDX_W'(NUM_RULES - 1);

  logic [WIN_W-1:0]     win_q;
  logic [IDR_W-1:0]     idr_q;
  logic [ATTR_W-1:0]    attr_q;
  logic [CMD_IDX_W-1:0] idx_q;
  logic [NUM_PORTS-1:0] def_q;
  rule_t                rules_q [NUM_RULES];

  logic [CMD_IDX_W-1:0] cmd_idx;
  logic                 cmd_in_range;
  logic                 cmd_commit;
  logic                 cmd_fetch;
  logic [IDX_W-1:0]     slot;

  always_comb begin
    cmd_idx      = cfg_wdata[CMD_IDX_W-1:0];
    cmd_in_range = (cmd_idx <= LAST_IDX);
    slot         = IDX_W'(cmd_idx);
    cmd_commit   = cfg_wdata[CMD_COMMIT_BIT] && cmd_in_range;
    cmd_fetch    = cfg_wdata[CMD_FETCH_BIT] && !cfg_wdata[CMD_COMMIT_BIT] && cmd_in_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      idr_q  <= '0;
      attr_q <= '0;
      idx_q  <= '0;
      def_q  <= '0;
      for (int i = 0; i < NUM_RULES; i++) rules_q[i] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_CMD: begin
          idx_q <= cmd_idx;
          if (cmd_commit)
            rules_q[slot] <= rule_t'({win_q, idr_q, attr_q});
          else if (cmd_fetch)
            {win_q, idr_q, attr_q} <= RULE_W'(rules_q[slot]);
        end
        SEL_WIN:  win_q  <= cfg_wdata[WIN_W-1:0];
        SEL_IDR:  idr_q  <= cfg_wdata[IDR_W-1:0];
        SEL_ATTR: attr_q <= cfg_wdata[ATTR_W-1:0];
        SEL_DEF:  def_q  <= cfg_wdata[NUM_PORTS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel_e'(cfg_sel))
      SEL_CMD:  cfg_rdata = CFG_W'(idx_q);
      SEL_WIN:  cfg_rdata = CFG_W'(win_q);
      SEL_IDR:  cfg_rdata = CFG_W'(idr_q);
      SEL_ATTR: cfg_rdata = CFG_W'(attr_q);
      SEL_DEF:  cfg_rdata = CFG_W'(def_q);
      default:  cfg_rdata = '0;
    endcase
  end

  assign rules_o    = rules_q;
  assign def_mask_o = def_q;
endmodule

// File: rtl/prc_match_unit.sv
module prc_match_unit
  import prc_pkg::*;
(
  input  logic [PAGE_W-1:0]    req_page,
  input  logic [ID_W-1:0]      req_id,
  input  logic [PORT_W-1:0]    req_port,
  input  logic                 req_secure,
  input  rule_t                rules_i [NUM_RULES],
  output logic [NUM_RULES-1:0] hit_o
);
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic [PORT_SPAN-1:0] mask_ext;
    logic                 in_window;
    logic                 in_ids;
    logic                 port_ok;
    logic                 sec_ok;

    always_comb begin
      mask_ext  = PORT_SPAN'(rules_i[g].port_mask);
      in_window = (req_page >= rules_i[g].page_lo) && (req_page <= rules_i[g].page_hi);
      in_ids    = (req_id >= rules_i[g].id_lo) && (req_id <= rules_i[g].id_hi);
      port_ok   = mask_ext[req_port];
      sec_ok    = req_secure ? rules_i[g].allow_s : rules_i[g].allow_ns;
      hit_o[g]  = rules_i[g].valid && in_window && in_ids && port_ok && sec_ok;
    end
  end
endmodule

// File: rtl/prc_prio_pick.sv
module prc_prio_pick
  import prc_pkg::*;
(
  input  logic [NUM_RULES-1:0] hit_i,
  input  logic [NUM_RULES-1:0] rej_i,
  output logic                 any_o,
  output logic                 rej_o
);
  always_comb begin
    any_o = |hit_i;
    rej_o = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hit_i[i]) rej_o = rej_i[i];
    end
  end
endmodule

// File: rtl/mem_prot_checker.sv
module mem_prot_checker
  import prc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [ID_W-1:0]   req_id,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_secure,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_reject
);
  rule_t                rules [NUM_RULES];
  logic [NUM_PORTS-1:0] def_mask;
  logic [NUM_RULES-1:0] hit_vec;
  logic [NUM_RULES-1:0] rej_vec;
  logic [NUM_RULES-1:0] valid_vec;
  logic                 hit_any;
  logic                 hit_rej;
  logic [PORT_SPAN-1:0] def_ext;
  logic                 verdict;
  logic                 resp_valid_q;
  logic                 resp_reject_q;

  prc_rule_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .rules_o    (rules),
    .def_mask_o (def_mask)
  );

  prc_match_unit u_match (
    .req_page   (req_page),
    .req_id     (req_id),
    .req_port   (req_port),
    .req_secure (req_secure),
    .rules_i    (rules),
    .hit_o      (hit_vec)
  );

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_flags
    assign rej_vec[g]   = rules[g].reject;
    assign valid_vec[g] = rules[g].valid;
  end

  prc_prio_pick u_pick (
    .hit_i (hit_vec),
    .rej_i (rej_vec),
    .any_o (hit_any),
    .rej_o (hit_rej)
  );

  // Ports past the last real one read as "reject" from the default.
  assign def_ext = {{(PORT_SPAN - NUM_PORTS){1'b1}}, def_mask};
  assign verdict = hit_any ? hit_rej : def_ext[req_port];

  assign req_ready = !resp_valid_q || resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_q  <= 1'b0;
      resp_reject_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      resp_valid_q  <= 1'b1;
      resp_reject_q <= verdict;
    end else if (resp_ready) begin
      resp_valid_q  <= 1'b0;
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_reject = resp_reject_q;
endmodule

// File: rtl/mem_prot_checker_sva.sv
module mem_prot_checker_sva
  import prc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [2:0]           cfg_sel,
  input logic [CFG_W-1:0]     cfg_wdata,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [PORT_W-1:0]    req_port,
  input logic                 resp_valid,
  input logic                 resp_ready,
  input logic                 resp_reject,
  input logic [NUM_RULES-1:0] valid_vec,
  input logic                 hit_any,
  input logic [NUM_PORTS-1:0] def_mask
);
  logic [PORT_SPAN-1:0] chk_def;
  logic                 take;
  logic                 commit_cmd;

  assign chk_def    = {{(PORT_SPAN - NUM_PORTS){1'b1}}, def_mask};
  assign take       = req_valid && req_ready;
  assign commit_cmd = cfg_we && (cfg_sel == 3'd0) && cfg_wdata[CMD_COMMIT_BIT];

  // R9: a taken request yields a verdict on the next cycle
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> resp_valid);

  // R9: back-pressure freezes the pending verdict
  p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_reject)));

  // R9: a drained response with nothing new behind it goes away
  p_resp_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready && !req_valid) |=> !resp_valid);

  // R2: rule valid bits move only on a commit command
  p_valid_commit_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_cmd |=> $stable(valid_vec));

  // R6: with no rule applying, the default bit of the port decides
  p_default_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit_any) |=> (resp_reject == $past(chk_def[req_port])));

  // R8: no verdict is pending while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r8: assert (!resp_valid);
  end
endmodule

bind mem_prot_checker mem_prot_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_port    (req_port),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_reject (resp_reject),
  .valid_vec   (valid_vec),
  .hit_any     (hit_any),
  .def_mask    (def_mask)
);

// File: tb/mem_prot_checker_test.sv
module mem_prot_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_page = '0;
  logic [11:0] req_id = '0;
  logic [3:0]  req_port = '0;
  logic        req_secure = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_reject;

  always #2.5 clk = ~clk;

  mem_prot_checker uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_page(req_page), .req_id(req_id),
    .req_port(req_port), .req_secure(req_secure), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_reject(resp_reject)
  );

  // Behavioural reference state
  int m_win, m_idr, m_attr, m_idx, m_def;
  int m_rwin [20];
  int m_ridr [20];
  int m_rattr [20];
  bit m_rv, m_rr;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R8";
  int    cycles = 0;

  function automatic bit ref_verdict(int page, int id, int port, bit sec);
    for (int i = 0; i < 20; i++) begin
      int a = m_rattr[i];
      bit ok = ((a >> 2) & 1) == 1;
      ok = ok && page >= (m_rwin[i] & 'hFFF) && page <= ((m_rwin[i] >> 12) & 'hFFF);
      ok = ok && id >= (m_ridr[i] & 'hFFF) && id <= ((m_ridr[i] >> 12) & 'hFFF);
      ok = ok && port < 10 && ((a >> (3 + port)) & 1) == 1;
      ok = ok && (sec ? (a & 1) : ((a >> 1) & 1)) == 1;
      if (ok) return bit'((a >> 13) & 1);
    end
    if (port < 10) return bit'((m_def >> port) & 1);
    return 1'b1;
  endfunction

  function automatic int ref_read(int sel);
    case (sel)
      0: return m_idx;
      1: return m_win;
      2: return m_idr;
      3: return m_attr;
      4: return m_def;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_win = 0; m_idr = 0; m_attr = 0; m_idx = 0; m_def = 0;
      m_rv = 0; m_rr = 0;
      for (int i = 0; i < 20; i++) begin
        m_rwin[i] = 0; m_ridr[i] = 0; m_rattr[i] = 0;
      end
    end else begin
      // Verdict first: it sees the table as it was before this edge.
      if (req_valid && (!m_rv || resp_ready)) begin
        m_rr = ref_verdict(int'(req_page), int'(req_id), int'(req_port), req_secure);
        m_rv = 1;
      end else if (resp_ready) begin
        m_rv = 0;
      end
      if (cfg_we) begin
        int d = int'(cfg_wdata);
        case (int'(cfg_sel))
          0: begin
            int ix = d & 'h1F;
            m_idx = ix;
            if (ix < 20) begin
              if ((d >> 5) & 1) begin
                m_rwin[ix] = m_win; m_ridr[ix] = m_idr; m_rattr[ix] = m_attr;
              end else if ((d >> 6) & 1) begin
                m_win = m_rwin[ix]; m_idr = m_ridr[ix]; m_attr = m_rattr[ix];
              end
            end
          end
          1: m_win  = d & 'hFFFFFF;
          2: m_idr  = d & 'hFFFFFF;
          3: m_attr = d & 'h3FFF;
          4: m_def  = d & 'h3FF;
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare();
    bit exp_rdy = !m_rv || resp_ready;
    logic [23:0] exp_rd = 24'(ref_read(int'(cfg_sel)));
    bit bad = 0;
    vectors++;
    if (resp_valid !== m_rv) bad = 1;
    if (m_rv && resp_reject !== m_rr) bad = 1;
    if (req_ready !== exp_rdy) bad = 1;
    if (cfg_rdata !== exp_rd) bad = 1;
    if (bad) begin
      miscompares++;
      $display("FAIL %s: actual valid=%0b reject=%0b ready=%0b rdata=%h, expected valid=%0b reject=%0b ready=%0b rdata=%h",
               tag, resp_valid, resp_reject, req_ready, cfg_rdata, m_rv, m_rr, exp_rdy, exp_rd);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic wr(int sel, int data);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 24'(data);
    step();
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic rd(int sel);
    cfg_sel = 3'(sel);
    step();
  endtask

  task automatic put_rule(int ix, int plo, int phi, int ilo, int ihi,
                          int sec, int mask, int valid, int rej);
    wr(1, plo | (phi << 12));
    wr(2, ilo | (ihi << 12));
    wr(3, sec | (valid << 2) | (mask << 3) | (rej << 13));
    wr(0, ix | 'h20);
    wr(0, 0);
  endtask

  task automatic send(int page, int id, int port, bit sec);
    req_valid = 1; req_page = 12'(page); req_id = 12'(id);
    req_port = 4'(port); req_secure = sec;
    step();
    req_valid = 0;
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL R9: watchdog expired, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tag = "R8";
    repeat (3) step();
    rst_n = 1;
    step();
    for (int s = 0; s < 8; s++) rd(s);

    // Default mask only
    tag = "R6";
    send('h123, 5, 0, 0);
    wr(4, 'h3FF);
    send('h123, 5, 3, 1);
    wr(4, 'h005);
    send('h123, 5, 0, 0);
    send('h123, 5, 1, 0);
    send('h123, 5, 2, 1);
    send('h123, 5, 12, 0);
    rd(4);

    // Window edges, default rejects everything
    tag = "R3";
    wr(4, 'h3FF);
    put_rule(0, 'h010, 'h01F, 0, 'hFFF, 3, 'h3FF, 1, 0);
    send('h00F, 1, 2, 1);
    send('h010, 1, 2, 1);
    send('h01F, 1, 2, 1);
    send('h020, 1, 2, 1);

    // ID range edges
    tag = "R4";
    put_rule(1, 'h800, 'hFFF, 'h100, 'h1FF, 3, 'h3FF, 1, 0);
    send('h800, 'h0FF, 0, 0);
    send('h800, 'h100, 0, 0);
    send('h900, 'h1FF, 0, 0);
    send('hFFF, 'h200, 0, 0);

    // Security field, port mask, valid and result bits
    tag = "R5";
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 1, 'h3FF, 1, 0);
    send('h410, 7, 0, 1);
    send('h410, 7, 0, 0);
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 2, 'h3FF, 1, 0);
    send('h410, 7, 0, 1);
    send('h410, 7, 0, 0);
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 0, 'h3FF, 1, 0);
    send('h410, 7, 0, 1);
    send('h410, 7, 0, 0);
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 3, 'h010, 1, 0);
    send('h410, 7, 4, 0);
    send('h410, 7, 5, 0);
    send('h410, 7, 3, 0);
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 3, 'h3FF, 0, 0);
    send('h410, 7, 4, 0);
    wr(4, 0);
    put_rule(2, 'h400, 'h4FF, 0, 'hFFF, 3, 'h3FF, 1, 1);
    send('h410, 7, 4, 0);
    send('h510, 7, 4, 0);

    // Overlapping rules: lowest number wins
    tag = "R7";
    put_rule(3, 'h100, 'h1FF, 0, 'hFFF, 3, 'h3FF, 1, 1);
    put_rule(7, 'h100, 'h1FF, 0, 'hFFF, 3, 'h3FF, 1, 0);
    send('h150, 9, 6, 1);
    put_rule(19, 'h300, 'h3FF, 0, 'hFFF, 3, 'h3FF, 1, 0);
    put_rule(18, 'h380, 'h3FF, 0, 'hFFF, 3, 'h3FF, 1, 1);
    wr(4, 'h3FF);
    send('h390, 9, 6, 1);
    send('h310, 9, 6, 1);
    put_rule(3, 0, 0, 0, 0, 0, 0, 0, 0);
    send('h150, 9, 6, 1);

    // Readback and command bit ordering
    tag = "R2";
    wr(0, 'h40 | 18);
    rd(1); rd(2); rd(3);
    wr(0, 0);
    wr(1, 'h600 | ('h6FF << 12));
    wr(2, 'hFFF << 12);
    wr(3, 3 | (1 << 2) | ('h3FF << 3));
    wr(0, 'h60 | 6);
    rd(1); rd(2); rd(3);
    send('h650, 1, 1, 0);
    wr(0, 'h40 | 0);
    rd(1); rd(3);
    send('h700, 1, 1, 0);

    // Index field and out-of-range numbers
    tag = "R1";
    wr(0, 19);
    rd(0);
    wr(1, 'h700 | ('h7FF << 12));
    wr(3, 3 | (1 << 2) | ('h3FF << 3));
    wr(0, 'h20 | 20);
    rd(0);
    send('h700, 1, 1, 0);
    wr(0, 'h40 | 25);
    rd(1); rd(3);
    wr(0, 'h40 | 19);
    rd(1); rd(2); rd(3);

    // Back-pressure
    tag = "R9";
    resp_ready = 0;
    req_valid = 1; req_page = 'h010; req_id = 1; req_port = 2; req_secure = 1;
    step();
    req_page = 'h020;
    step(); step(); step();
    resp_ready = 1;
    step();
    req_valid = 0;
    step(); step();
    req_valid = 1; req_page = 'h020;
    step();
    req_page = 'h010;
    step();
    req_valid = 0;
    step();

    // Request alongside a commit
    tag = "R10";
    wr(1, 'h010 | ('h01F << 12));
    wr(2, 'hFFF << 12);
    wr(3, 3 | (1 << 2) | ('h3FF << 3) | (1 << 13));
    cfg_sel = 0; cfg_we = 1; cfg_wdata = 24'('h20);
    req_valid = 1; req_page = 'h015; req_id = 3; req_port = 1; req_secure = 0;
    step();
    cfg_we = 0; cfg_wdata = '0; req_valid = 0;
    step();
    send('h015, 3, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule